// File: doc/BRIEF.md
# Memory-Indirect Effective Address Generator

This block forms an effective address that depends on a word held in memory. From a base register value and a base displacement it builds a pointer, reads one 32-bit word at that pointer through a request/acknowledge read port, and then adds an outer displacement and an optional scaled index register to that word. The finished address is returned with a one-cycle completion strobe. Because a memory read sits between the two adder stages, the block is a small sequencer rather than a combinational adder.

A start pulse latches all operands. A bypass input skips the read. In that case the result is the pointer plus the scaled index, which is the plain register-indirect-with-index form. A parameter narrows the visible address to fewer bits for a reduced address bus. With the width set to 24, the block covers 16 MiB instead of 4 GiB.

Top module: `mem_indirect_ea`

## Requirements
- R1: After an accepted start on the memory path, `mem_req` rises with `mem_addr` equal to `base_reg + base_disp`, masked to `OUT_W` bits.
- R2: `mem_req` and `mem_addr` stay unchanged until `mem_ack` is sampled high. An acknowledge in the first request cycle is accepted. `mem_req` is low in the cycle after the acknowledge.
- R3: `mem_rdata` is captured in the cycle `mem_ack` is high. The result is `word + outer_disp + (index_reg << scale)`, where scale code 0, 1, 2 and 3 shifts by 0, 1, 2 and 3 bits.
- R4: When `index_en` is 0, the index term is zero, whatever the values of `index_reg` and `scale`.
- R5: Every addition wraps modulo 2^32 and no overflow is signalled. This includes a shifted index that loses its top bits.
- R6: When `skip_mem` is 1, no memory request is made. The result is `base_reg + base_disp + scaled index`, and `outer_disp` is unused. `done` is high in the third cycle after the start cycle.
- R7: On the memory path, `done` is high for exactly one cycle, two cycles after the acknowledge cycle. `ea_out` changes only when `done` rises and otherwise holds its value.
- R8: A start while `busy` is high is ignored. The running operation's result is unchanged and no extra operation follows.
- R9: With `OUT_W` = 24, bits 31..24 of `mem_addr` and `ea_out` are zero, and the lower 24 bits match the full-width result.
- R10: After reset, `done`, `mem_req` and `busy` are 0 and `ea_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| base_reg | input | 32 | Base register value |
| base_disp | input | 32 | Base displacement, already sign-extended |
| outer_disp | input | 32 | Outer displacement, already sign-extended |
| index_reg | input | 32 | Index register value |
| scale | input | 2 | Index shift amount, 0 to 3 |
| index_en | input | 1 | 1 adds the index term, 0 drops it |
| skip_mem | input | 1 | 1 bypasses the memory read |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address (the pointer) |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| ea_out | output | 32 | Final effective address |

## Verification
The bench attacks the pointer wraparound, scale code 3 on an index whose top bits fall off, an index that is disabled but holds nonzero values, an acknowledge in the very first request cycle, and long acknowledge delays. A design that latched read data a cycle late would return a stale word. A design that mis-mapped the scale code or forgot to gate the index would produce an address off by a shifted index. A stray start during a read would, in a faulty design, restart or corrupt the operation and give a second done. The bypass mode is also checked: a request leaking out in that mode, or the outer displacement being added, would each show up. A second instance at 24-bit width must have clean upper bits.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int ADDR_W = 32;
    localparam int SCALE_W = 2;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PTR   = 3'd1,
        S_REQ   = 3'd2,
        S_WAIT  = 3'd3,
        S_FINAL = 3'd4,
        S_DONE  = 3'd5
    } seq_state_t;

    typedef struct packed {
        addr_t              base;
        addr_t              bdisp;
        addr_t              odisp;
        addr_t              index;
        logic [SCALE_W-1:0] scale;
        logic               index_en;
        logic               skip;
    } ea_ops_t;

    function automatic addr_t width_mask(input int w);
        addr_t m;
        for (int i = 0; i < ADDR_W; i++) m[i] = (i < w);
        return m;
    endfunction
endpackage

// File: rtl/ea_index_scaler.sv
module ea_index_scaler
    import ea_pkg::*;
(
    input  addr_t              index,
    input  logic [SCALE_W-1:0] scale,
    input  logic               enable,
    output addr_t              term
);
    always_comb begin
        if (enable) term = index << scale;
        else        term = '0;
    end
endmodule

// File: rtl/ea_add3.sv
module ea_add3 #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sum
);
    assign sum = a + b + c;
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
    import ea_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       skip,
    input  logic       ack,
    output seq_state_t state
);
    seq_state_t nxt;

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE:  if (start) nxt = S_PTR;
            S_PTR:   nxt = skip ? S_FINAL : S_REQ;
            S_REQ:   nxt = ack ? S_FINAL : S_WAIT;
            S_WAIT:  if (ack) nxt = S_FINAL;
            S_FINAL: nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/mem_indirect_ea.sv
module mem_indirect_ea
    import ea_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] base_reg,
    input  logic [31:0] base_disp,
    input  logic [31:0] outer_disp,
    input  logic [31:0] index_reg,
    input  logic [1:0]  scale,
    input  logic        index_en,
    input  logic        skip_mem,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [31:0] ea_out
);
    localparam addr_t OUT_MASK = width_mask(OUT_W);

    seq_state_t state;
    ea_ops_t    ops;
    addr_t      ptr_q, word_q, ea_q;
    addr_t      idx_term, ptr_sum, fin_a, fin_b, fin_sum;

    ea_sequencer u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .skip  (ops.skip),
        .ack   (mem_ack),
        .state (state)
    );

    ea_index_scaler u_scale (
        .index  (ops.index),
        .scale  (ops.scale),
        .enable (ops.index_en),
        .term   (idx_term)
    );

    ea_add3 #(.W(ADDR_W)) u_ptr_add (
        .a   (ops.base),
        .b   (ops.bdisp),
        .c   ('0),
        .sum (ptr_sum)
    );

    // bypass path: pointer + index; memory path: word + outer + index
    assign fin_a = ops.skip ? ptr_q : word_q;
    assign fin_b = ops.skip ? '0    : ops.odisp;

    ea_add3 #(.W(ADDR_W)) u_fin_add (
        .a   (fin_a),
        .b   (fin_b),
        .c   (idx_term),
        .sum (fin_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ops    <= '0;
            ptr_q  <= '0;
            word_q <= '0;
            ea_q   <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                ops.base     <= base_reg;
                ops.bdisp    <= base_disp;
                ops.odisp    <= outer_disp;
                ops.index    <= index_reg;
                ops.scale    <= scale;
                ops.index_en <= index_en;
                ops.skip     <= skip_mem;
            end
            if (state == S_PTR) ptr_q <= ptr_sum;
            if ((state == S_REQ || state == S_WAIT) && mem_ack) word_q <= mem_rdata;
            if (state == S_FINAL) ea_q <= fin_sum;
        end
    end

    assign mem_req  = (state == S_REQ) || (state == S_WAIT);
    assign mem_addr = ptr_q & OUT_MASK;
    assign busy     = (state != S_IDLE);
    assign done     = (state == S_DONE);
    assign ea_out   = ea_q & OUT_MASK;
endmodule

// File: rtl/ea_checker.sv
module ea_checker
    import ea_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] ea_out
);
    localparam addr_t HI_MASK = ~width_mask(OUT_W);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R2
    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> !mem_req); // R2
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_EA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !$stable(ea_out) |-> $rose(done)); // R7
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        (mem_req || done) |-> busy); // R8

    always_comb begin
        if (!rst) begin
            AST_HI_ZERO: assert (((ea_out | mem_addr) & HI_MASK) == '0); // R9
        end
    end
endmodule

bind mem_indirect_ea ea_checker #(.OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .ea_out   (ea_out)
);

// File: tb/mem_indirect_ea_test.sv
module mem_indirect_ea_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0;
    logic [31:0] base_reg = 0, base_disp = 0, outer_disp = 0, index_reg = 0;
    logic [1:0]  scale = 0;
    logic        index_en = 0, skip_mem = 0;
    logic        mem_ack = 0;
    logic [31:0] mem_rdata = 0;
    logic        mem_req, busy, done;
    logic [31:0] mem_addr, ea_out;
    logic        mem_req24, busy24, done24;
    logic [31:0] mem_addr24, ea_out24;

    int total = 0, bad = 0;
    int cyc = 0;
    int ack_delay = 0, req_cnt = 0, ack_cyc = 0;
    bit saw_req = 0;
    logic [31:0] exp_ptr = 0, hold_addr = 0;

    localparam logic [31:0] M24 = 32'h00FF_FFFF;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    mem_indirect_ea uut (
        .clk(clk), .rst(rst), .start(start), .base_reg(base_reg), .base_disp(base_disp),
        .outer_disp(outer_disp), .index_reg(index_reg), .scale(scale), .index_en(index_en),
        .skip_mem(skip_mem), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .ea_out(ea_out));

    mem_indirect_ea #(.OUT_W(24)) uut24 (
        .clk(clk), .rst(rst), .start(start), .base_reg(base_reg), .base_disp(base_disp),
        .outer_disp(outer_disp), .index_reg(index_reg), .scale(scale), .index_en(index_en),
        .skip_mem(skip_mem), .mem_req(mem_req24), .mem_addr(mem_addr24), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy24), .done(done24), .ea_out(ea_out24));

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
    endfunction

    function automatic logic [31:0] idx_term(input logic [31:0] i, input logic [1:0] s, input logic en);
        return en ? (i << s) : 32'd0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    // memory responder
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 0;
        end else if (mem_req) begin
            saw_req = 1;
            if (req_cnt == 0) begin
                chk(mem_addr == exp_ptr, "R1 pointer", mem_addr, exp_ptr);
                chk(mem_addr24 == (exp_ptr & M24), "R9 narrow pointer", mem_addr24, exp_ptr & M24);
                hold_addr = mem_addr;
            end else begin
                chk(mem_addr == hold_addr, "R2 addr held", mem_addr, hold_addr);
            end
            if (req_cnt == ack_delay) begin
                mem_ack = 1;
                mem_rdata = mem_word(mem_addr);
                ack_cyc = cyc;
            end
            req_cnt++;
        end else begin
            req_cnt = 0;
        end
    end

    task automatic run_op(input logic [31:0] b, input logic [31:0] bd, input logic [31:0] od,
                          input logic [31:0] ix, input logic [1:0] sc, input logic en,
                          input logic sk, input int dly, input bit inject);
        logic [31:0] exp_ea, ea_seen;
        int start_cyc, n;
        bit got;
        exp_ptr = b + bd;
        exp_ea = sk ? (exp_ptr + idx_term(ix, sc, en))
                    : (mem_word(exp_ptr) + od + idx_term(ix, sc, en));
        ack_delay = dly;
        saw_req = 0;
        @(negedge clk);
        base_reg = b; base_disp = bd; outer_disp = od; index_reg = ix;
        scale = sc; index_en = en; skip_mem = sk; start = 1;
        start_cyc = cyc;
        @(negedge clk);
        start = 0;
        got = 0;
        n = 0;
        while (!got && n < 60) begin
            if (inject && n == 2) begin
                start = 1; base_reg = ~b; outer_disp = od ^ 32'h1234;
            end else begin
                start = 0;
            end
            if (done) begin
                got = 1;
                chk(ea_out == exp_ea, "R3/R4/R5 result", ea_out, exp_ea);
                chk(ea_out24 == (exp_ea & M24), "R9 narrow result", ea_out24, exp_ea & M24);
                chk(done24 == 1'b1, "R9 narrow done", {31'd0, done24}, 32'd1);
                if (sk) begin
                    chk(cyc - start_cyc == 3, "R6 bypass latency", cyc - start_cyc, 3);
                    chk(!saw_req, "R6 no request", {31'd0, saw_req}, 0);
                end else begin
                    chk(cyc - ack_cyc == 2, "R7 done timing", cyc - ack_cyc, 2);
                end
                ea_seen = ea_out;
            end else begin
                @(negedge clk);
                n++;
            end
        end
        start = 0;
        if (!got) chk(0, "R7 done never seen", 0, 1);
        @(negedge clk);
        chk(!done, "R7 done one cycle", {31'd0, done}, 0);
        chk(ea_out == ea_seen, "R7 ea held", ea_out, ea_seen);
        if (inject) chk(!busy, "R8 start ignored", {31'd0, busy}, 0);
        repeat (2) @(negedge clk);
        chk(ea_out == ea_seen, "R7 ea held idle", ea_out, ea_seen);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk(!done && !mem_req && !busy, "R10 reset outputs", {29'd0, done, mem_req, busy}, 0);
        chk(ea_out == 0, "R10 reset ea", ea_out, 0);
        rst = 0;
        @(negedge clk);
        chk(!busy && !mem_req, "R10 idle after reset", {30'd0, busy, mem_req}, 0);

        // directed corners
        run_op(32'h1000_0000, 32'h0000_0040, 32'h0000_0008, 32'h10, 2'd0, 1, 0, 0, 0); // R2 ack at once
        run_op(32'h1000_0000, 32'h0000_0040, 32'h0000_0008, 32'h10, 2'd3, 1, 0, 7, 0); // R3 scale 3
        run_op(32'hFFFF_FFF0, 32'h0000_0020, 32'hFFFF_FFFC, 32'h8000_0001, 2'd3, 1, 0, 2, 0); // R5 wrap
        run_op(32'h0000_1000, 32'h0000_0004, 32'h0000_0100, 32'hDEAD_BEEF, 2'd2, 0, 0, 1, 0); // R4 disabled
        run_op(32'h0012_3400, 32'hFFFF_FF00, 32'h5555_5555, 32'h0000_0003, 2'd1, 1, 1, 0, 0); // R6 bypass
        run_op(32'hABCD_0000, 32'h0000_1234, 32'h0000_0010, 32'h0000_0005, 2'd2, 1, 0, 4, 1); // R8 inject

        for (int k = 0; k < 300; k++) begin
            run_op($urandom, $urandom, $urandom, $urandom, 2'($urandom_range(0, 3)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
                   $urandom_range(0, 5), ($urandom_range(0, 7) == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule